// File: doc/BRIEF.md
# Hybrid Cache Mode Selection Controller

This controller chooses, while the system runs, whether a last-level cache should work as a small, fast SRAM cache or as a large, slow DRAM cache. Time is measured in cache accesses, not clock cycles. A measurement sequence has two parts. The first interval of a programmed number of accesses runs in SRAM mode and counts its misses. A second interval of equal length runs in DRAM mode and counts its misses. The controller then compares the two miss counts.

DRAM mode wins when the misses it saves, each costing one main-memory access time, outweigh the extra hit latency it adds on every access of the interval. The test uses only multiplication, so no divider is needed. The chosen mode then holds for a programmed number of intervals. After that a new measurement sequence begins at once.

The mode output is meant to steer the cache arrays. A one-cycle switch request lets the surrounding logic start whatever a reconfiguration needs. The busy flag marks the measurement phase.

Top module: `hybrid_mode_sel`

## Requirements
- R1: After reset the mode output is 0 (SRAM; 1 means DRAM), busy is 0 and the switch request is 0. The first access after reset starts a measurement sequence and is not itself counted. Busy is 1 from the cycle after that access.
- R2: Each interval is exactly L accesses, where L is the latched interval length and a value of 0 is treated as 1. The SRAM measurement interval runs with mode 0. The mode turns to 1 in the cycle after the SRAM interval's last access, and the DRAM measurement interval then runs with mode 1.
- R3: A miss strobe counts only in a cycle where the access strobe is also high. A miss strobe without an access has no effect.
- R4: With S and D the SRAM and DRAM miss counts, T the memory access time and H_s and H_d the hit latencies, DRAM mode is selected exactly when (S − D) × T > (H_d − H_s) × L. The latency gap is taken as 0 when H_d ≤ H_s.
- R5: When S ≤ D, SRAM mode is selected regardless of the other values.
- R6: The decided mode appears two cycles after the last access of the DRAM interval. Busy stays 1 through the decision cycle and drops with the new mode.
- R7: The run phase lasts R × L accesses, where R is the latched run-interval count and 0 is treated as 1. Busy is 0 during the run phase. The last run access starts a new sequence directly, with mode 0 and busy 1 from the next cycle.
- R8: The switch request is high for exactly the one cycle in which the mode output shows a changed value, and it is low at all other times.
- R9: All configuration inputs are captured only on the access that starts a sequence. Changing them in mid-sequence does not alter that sequence's decision or lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accessIn | input | 1 | One cache access this cycle |
| missIn | input | 1 | The access this cycle missed |
| cfgHitSram | input | LAT_W | Hit latency in SRAM mode (cycles) |
| cfgHitDram | input | LAT_W | Hit latency in DRAM mode (cycles) |
| cfgMemTime | input | MEM_W | Main-memory access time (cycles) |
| cfgIntervalLen | input | CNT_W | Accesses per interval |
| cfgRunIntervals | input | RUN_W | Intervals in the run phase |
| modeDram | output | 1 | Current mode, 1 = DRAM |
| switchReq | output | 1 | One-cycle pulse on a mode change |
| busy | output | 1 | Measurement sequence in progress |

## Verification
The decision threshold is the hardest point to reach from the ports. Hitting it needs an exact pair of miss counts, placed into two separate intervals, for a memory time that makes the two products equal or differ by one. The bench uses a four-access interval and sweeps every pair of miss counts from 0 to 4 for each interval. It repeats the sweep with memory times on both sides of the equality point, which covers the tie (kept in SRAM) and the smallest win (DRAM).

Configuration captured in mid-sequence is reached by changing the inputs inside a measurement interval. The decision must still follow the values held at the sequence start. Misses without an access are injected inside a measured interval.

// File: rtl/hms_pkg.sv
package hms_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEAS_S,
    ST_MEAS_D,
    ST_DECIDE,
    ST_RUN
  } state_t;

  typedef struct packed {
    logic latchCfg;
    logic clrCnt;
    logic countEn;
    logic saveSram;
    logic saveDram;
    logic runCount;
  } strobe_t;
endpackage

// File: rtl/hms_dpath.sv
module hms_dpath
  import hms_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int LAT_W = 8,
  parameter int MEM_W = 16,
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          st,
  input  logic             accessIn,
  input  logic             missIn,
  input  logic [LAT_W-1:0] cfgHitSram,
  input  logic [LAT_W-1:0] cfgHitDram,
  input  logic [MEM_W-1:0] cfgMemTime,
  input  logic [CNT_W-1:0] cfgIntervalLen,
  input  logic [RUN_W-1:0] cfgRunIntervals,
  output logic             intervalDone,
  output logic             runDone,
  output logic             dramBetter
);
  localparam int WIDE_W = (MEM_W > LAT_W) ? MEM_W : LAT_W;
  localparam int PROD_W = CNT_W + WIDE_W;

  logic [LAT_W-1:0] hitS, hitD, penalty;
  logic [MEM_W-1:0] memT;
  logic [CNT_W-1:0] lenR, lenEff, accCnt, missCnt, missTotal, missS, missD, diffMiss;
  logic [RUN_W-1:0] runR, runEff, runCnt;
  logic [PROD_W-1:0] gainProd, costProd;

  assign lenEff = (lenR == '0) ? CNT_W'(1) : lenR;
  assign runEff = (runR == '0) ? RUN_W'(1) : runR;
  assign intervalDone = accessIn && st.countEn && (accCnt == lenEff - CNT_W'(1));
  assign runDone = intervalDone && st.runCount && (runCnt == runEff - RUN_W'(1));
  assign missTotal = missCnt + CNT_W'(missIn);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hitS <= '0; hitD <= '0; memT <= '0; lenR <= '0; runR <= '0;
    end else if (st.latchCfg) begin
      hitS <= cfgHitSram; hitD <= cfgHitDram; memT <= cfgMemTime;
      lenR <= cfgIntervalLen; runR <= cfgRunIntervals;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st.clrCnt) begin
      accCnt <= '0;
      missCnt <= '0;
    end else if (accessIn && st.countEn) begin
      if (intervalDone) begin
        accCnt <= '0;
        missCnt <= '0;
      end else begin
        accCnt <= accCnt + CNT_W'(1);
        missCnt <= missTotal;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      missS <= '0;
      missD <= '0;
    end else begin
      if (intervalDone && st.saveSram) missS <= missTotal;
      if (intervalDone && st.saveDram) missD <= missTotal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st.clrCnt || st.latchCfg) runCnt <= '0;
    else if (intervalDone && st.runCount) runCnt <= runDone ? '0 : runCnt + RUN_W'(1);
  end

  // Division-free cost test on equal-length intervals.
  assign diffMiss = missS - missD;
  assign penalty  = (hitD > hitS) ? hitD - hitS : '0;
  assign gainProd = PROD_W'(diffMiss) * PROD_W'(memT);
  assign costProd = PROD_W'(penalty) * PROD_W'(lenEff);
  assign dramBetter = (missS > missD) && (gainProd > costProd);

  // R2
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n) accCnt < lenEff);
  // R3
  miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) missCnt <= accCnt);
endmodule

// File: rtl/hms_ctrl.sv
module hms_ctrl
  import hms_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    accessIn,
  input  logic    intervalDone,
  input  logic    runDone,
  input  logic    dramBetter,
  output strobe_t st,
  output logic    modeDram,
  output logic    switchReq,
  output logic    busy
);
  state_t state, stateNext;
  logic   modeNext;

  always_comb begin
    stateNext = state;
    modeNext  = modeDram;
    st        = '0;
    case (state)
      ST_IDLE: begin
        st.clrCnt = 1'b1;
        if (accessIn) begin
          st.latchCfg = 1'b1;
          stateNext   = ST_MEAS_S;
          modeNext    = 1'b0;
        end
      end
      ST_MEAS_S: begin
        st.countEn  = 1'b1;
        st.saveSram = 1'b1;
        if (intervalDone) begin
          stateNext = ST_MEAS_D;
          modeNext  = 1'b1;
        end
      end
      ST_MEAS_D: begin
        st.countEn  = 1'b1;
        st.saveDram = 1'b1;
        if (intervalDone) stateNext = ST_DECIDE;
      end
      ST_DECIDE: begin
        st.clrCnt = 1'b1;
        stateNext = ST_RUN;
        modeNext  = dramBetter;
      end
      ST_RUN: begin
        st.countEn  = 1'b1;
        st.runCount = 1'b1;
        if (runDone) begin
          st.latchCfg = 1'b1;
          stateNext   = ST_MEAS_S;
          modeNext    = 1'b0;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      modeDram  <= 1'b0;
      switchReq <= 1'b0;
    end else begin
      state     <= stateNext;
      modeDram  <= modeNext;
      switchReq <= (modeNext != modeDram);
    end
  end

  assign busy = (state == ST_MEAS_S) || (state == ST_MEAS_D) || (state == ST_DECIDE);

  // R8
  switch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) switchReq |=> !switchReq);
  // R8
  mode_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeDram != $past(modeDram)) |-> switchReq);
  // R2
  sram_meas_chk: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_MEAS_S) |-> !modeDram);
  // R2
  dram_meas_chk: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_MEAS_D) |-> modeDram);
  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_IDLE) |-> (!modeDram && !busy));
endmodule

// File: rtl/hybrid_mode_sel.sv
module hybrid_mode_sel
  import hms_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int LAT_W = 8,
  parameter int MEM_W = 16,
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accessIn,
  input  logic             missIn,
  input  logic [LAT_W-1:0] cfgHitSram,
  input  logic [LAT_W-1:0] cfgHitDram,
  input  logic [MEM_W-1:0] cfgMemTime,
  input  logic [CNT_W-1:0] cfgIntervalLen,
  input  logic [RUN_W-1:0] cfgRunIntervals,
  output logic             modeDram,
  output logic             switchReq,
  output logic             busy
);
  strobe_t st;
  logic intervalDone, runDone, dramBetter;

  hms_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .accessIn(accessIn), .intervalDone(intervalDone),
    .runDone(runDone), .dramBetter(dramBetter), .st(st), .modeDram(modeDram),
    .switchReq(switchReq), .busy(busy)
  );

  hms_dpath #(.CNT_W(CNT_W), .LAT_W(LAT_W), .MEM_W(MEM_W), .RUN_W(RUN_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .st(st), .accessIn(accessIn), .missIn(missIn),
    .cfgHitSram(cfgHitSram), .cfgHitDram(cfgHitDram), .cfgMemTime(cfgMemTime),
    .cfgIntervalLen(cfgIntervalLen), .cfgRunIntervals(cfgRunIntervals),
    .intervalDone(intervalDone), .runDone(runDone), .dramBetter(dramBetter)
  );
endmodule

// File: tb/hybrid_mode_sel_test.sv
module hybrid_mode_sel_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic accessIn = 1'b0, missIn = 1'b0;
  logic [7:0]  cfgHitSram = 8'd6, cfgHitDram = 8'd28;
  logic [15:0] cfgMemTime = 16'd200;
  logic [23:0] cfgIntervalLen = 24'd4;
  logic [7:0]  cfgRunIntervals = 8'd1;
  logic modeDram, switchReq, busy;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int latL = 4, latR = 1, latMem = 200;
  int curMode = 0;

  always #2 clk = ~clk;

  hybrid_mode_sel uut (
    .clk(clk), .rst_n(rst_n), .accessIn(accessIn), .missIn(missIn),
    .cfgHitSram(cfgHitSram), .cfgHitDram(cfgHitDram), .cfgMemTime(cfgMemTime),
    .cfgIntervalLen(cfgIntervalLen), .cfgRunIntervals(cfgRunIntervals),
    .modeDram(modeDram), .switchReq(switchReq), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doAccess(input logic m);
    @(negedge clk); accessIn = 1'b1; missIn = m;
    @(negedge clk); accessIn = 1'b0; missIn = 1'b0;
  endtask

  task automatic interval(input int n, input int misses);
    for (int i = 0; i < n; i++) doAccess(i < misses);
  endtask

  function automatic int expDram(input int s, input int d, input int mem, input int l);
    return ((s > d) && ((s - d) * mem > 22 * l)) ? 1 : 0;
  endfunction

  // Runs one measurement sequence; the sequence must already have started.
  task automatic measure(input int s, input int d, input int exp, input string tag);
    interval(latL, s);
    chk({tag, " R2 mode after SRAM interval"}, int'(modeDram), 1);
    chk({tag, " R8 pulse on entry to DRAM interval"}, int'(switchReq), 1);
    interval(latL, d);
    chk({tag, " R6 busy in decision cycle"}, int'(busy), 1);
    @(negedge clk);
    chk({tag, " R4 R5 decided mode"}, int'(modeDram), exp);
    chk({tag, " R8 pulse on decision"}, int'(switchReq), (exp != 1) ? 1 : 0);
    chk({tag, " R6 busy after decision"}, int'(busy), 0);
    curMode = exp;
  endtask

  // Runs the whole run phase; its last access starts a new sequence.
  task automatic runPhase(input string tag);
    interval(latR * latL - 1, 0);
    chk({tag, " R7 busy low in run"}, int'(busy), 0);
    chk({tag, " R7 mode held in run"}, int'(modeDram), curMode);
    latL = (cfgIntervalLen == 0) ? 1 : int'(cfgIntervalLen);
    latR = (cfgRunIntervals == 0) ? 1 : int'(cfgRunIntervals);
    latMem = int'(cfgMemTime);
    doAccess(1'b0);
    chk({tag, " R7 new sequence busy"}, int'(busy), 1);
    chk({tag, " R7 new sequence mode"}, int'(modeDram), 0);
    chk({tag, " R8 pulse on return to SRAM"}, int'(switchReq), curMode);
    curMode = 0;
  endtask

  initial begin
    int mems[4];
    int runs[4];
    mems = '{22, 23, 200, 10};
    runs = '{1, 2, 1, 1};
    repeat (3) @(negedge clk);
    chk("R1 reset mode", int'(modeDram), 0);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset switch", int'(switchReq), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle before access", int'(busy), 0);
    // R9: config latched at start; later changes ignored.
    doAccess(1'b1);
    chk("R1 busy after first access", int'(busy), 1);
    chk("R1 mode SRAM in first interval", int'(modeDram), 0);
    cfgMemTime = 16'd10;
    cfgIntervalLen = 24'd7;
    // R3: miss strobes without access inside the SRAM interval.
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); missIn = 1'b1;
      @(negedge clk); missIn = 1'b0;
      doAccess(i == 0);
    end
    interval(1, 0);
    chk("R3 R9 mode after 4-access SRAM interval", int'(modeDram), 1);
    interval(4, 0);
    @(negedge clk);
    // S=1,D=0,T=200: 200>88 -> DRAM; latched T, not 10; L stays 4.
    chk("R9 R3 decision uses latched config", int'(modeDram), 1);
    curMode = 1;
    cfgIntervalLen = 24'd4;
    // Sweep over miss pairs for several memory times and run lengths.
    for (int g = 0; g < 4; g++) begin
      for (int s = 0; s <= 4; s++) begin
        for (int d = 0; d <= 4; d++) begin
          string tag;
          cfgMemTime = 16'(mems[g]);
          cfgRunIntervals = 8'(runs[g]);
          runPhase($sformatf("g%0d s%0d d%0d", g, s, d));
          tag = $sformatf("mem%0d s%0d d%0d", latMem, s, d);
          measure(s, d, expDram(s, d, latMem, latL), tag);
        end
      end
    end
    // R2 R7: zero length and zero run count act as one.
    cfgIntervalLen = 24'd0;
    cfgRunIntervals = 8'd0;
    cfgMemTime = 16'd200;
    runPhase("R2 zero-length entry");
    measure(1, 0, expDram(1, 0, 200, 1), "R2 zero length");
    runPhase("R7 zero run count");
    chk("R7 zero run count restarts", int'(busy), 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule